// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block is the fetch front end of a small 8-bit processor with a 16-bit program counter. It puts the program counter on the address bus in every cycle and reads one byte per cycle. In the first cycle of an instruction the byte is loaded into the instruction register. In the following cycles the bytes go into a 16-bit operand latch. An external decode stage supplies a two-bit length class that tells the sequencer how many operand bytes the opcode needs.

The cycle after an opcode fetch always reads memory at the new program counter, whether or not the opcode takes an operand. The counter moves forward only when that byte is really consumed. A no-operand instruction therefore takes two cycles, and its second cycle is a dummy read that the next opcode fetch repeats at the same address. An instruction with one operand byte takes two cycles and one with two operand bytes takes three. In each cycle the address is driven from the current counter value while the incremented value is prepared for the next cycle, so the bus read and the increment overlap.

Top module: `insn_fetch_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter loads `reset_vector`, `cycle_idx` returns to 0, and `opcode_q` and `operand_q` clear to zero. `bus_rd` is low while `rst` is high.
- R2: In the opcode cycle (`cycle_idx` = 0), `bus_addr` equals the program counter and `bus_rd` is high. The byte on `bus_rdata` is loaded into `opcode_q`, and the counter advances by one for the next cycle.
- R3: The cycle after the opcode fetch (`cycle_idx` = 1) always reads at the opcode address plus one with `bus_rd` high. When the opcode has no operand, this read is a dummy: `operand_q` is left unchanged and the next opcode fetch uses the same address.
- R4: With one operand byte, the read in `cycle_idx` = 1 is stored as `operand_q` = {8'h00, byte}, and the counter advances by one.
- R5: With two operand bytes, the low byte is captured in `cycle_idx` = 1 as in R4. In `cycle_idx` = 2 the byte read at the next address goes into `operand_q[15:8]`, and the counter advances by one again.
- R6: `len_class` is sampled in `cycle_idx` = 1 with this encoding: 2'b00 means no operand, 2'b01 means one operand byte, 2'b10 means two operand bytes, and 2'b11 is treated as no operand. `cycle_idx` only takes the values 0, 1 and 2.
- R7: `fetch_done` is high only in the last fetch cycle of an instruction, and the following cycle is an opcode fetch. An instruction lasts 2 cycles for 0 or 1 operand bytes and 3 cycles for 2 operand bytes.
- R8: The program counter wraps from 16'hFFFF to 16'h0000 when it advances, in any cycle.
- R9: `opcode_q` does not change in operand or dummy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reset_vector | input | 16 | Value loaded into the program counter on reset |
| len_class | input | 2 | Operand length class decoded from `opcode_q` |
| bus_rdata | input | 8 | Byte returned by memory for `bus_addr` in the same cycle |
| bus_addr | output | 16 | Address bus, equal to the program counter |
| bus_rd | output | 1 | Read strobe |
| opcode_q | output | 8 | Instruction register |
| operand_q | output | 16 | Operand latch, low byte captured first |
| cycle_idx | output | 2 | Current fetch cycle: 0 opcode, 1 first operand or dummy, 2 second operand |
| fetch_done | output | 1 | High in the last fetch cycle of an instruction |

## Verification
The program counter increment and the bus read fall in the same cycle: the address shown in a cycle must be the value from before the increment, and the incremented value must appear on the bus in the next cycle. This is provoked with instruction streams that mix every length class, including the 2'b11 class and no-operand instructions whose dummy read is followed by a fetch at the same address. Streams are also started just below 16'hFFFF so that the wrap falls in an opcode cycle, in an operand cycle and in a dummy cycle. A scoreboard predicts the opcode address, the dummy-read address, the cycle count, the captured operand and the next opcode address for each instruction, and compares each prediction with the ports.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [1:0] {
    PH_OPC = 2'd0,
    PH_OP1 = 2'd1,
    PH_OP2 = 2'd2
  } phase_e;

  // Operand byte count for a length class; class 2'b11 means no operand.
  function automatic logic [1:0] operand_count(input logic [1:0] cls);
    case (cls)
      2'b01:   operand_count = 2'd1;
      2'b10:   operand_count = 2'd2;
      default: operand_count = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reset_vector,
  input  logic          step,
  output logic [AW-1:0] pc
);

  // Full-width increment that wraps to zero.
  function automatic logic [AW-1:0] pc_plus_one(input logic [AW-1:0] v);
    pc_plus_one = v + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  logic [AW-1:0] pc_nxt;

  assign pc_nxt = pc_plus_one(pc);

  always_ff @(posedge clk) begin
    if (rst)       pc <= reset_vector;
    else if (step) pc <= pc_nxt;
  end

endmodule

// File: rtl/fetch_phase_ctrl.sv
module fetch_phase_ctrl
  import fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] len_class,
  output phase_e     phase,
  output logic       pc_step,
  output logic       ir_load,
  output logic       lo_load,
  output logic       hi_load,
  output logic       dummy_rd,
  output logic       done
);

  phase_e     phase_nxt;
  logic [1:0] n_ops;

  assign n_ops = operand_count(len_class);

  always_comb begin
    pc_step   = 1'b0;
    ir_load   = 1'b0;
    lo_load   = 1'b0;
    hi_load   = 1'b0;
    dummy_rd  = 1'b0;
    done      = 1'b0;
    phase_nxt = PH_OPC;
    case (phase)
      PH_OPC: begin
        pc_step   = 1'b1;
        ir_load   = 1'b1;
        phase_nxt = PH_OP1;
      end
      PH_OP1: begin
        if (n_ops == 2'd0) begin
          dummy_rd = 1'b1;
          done     = 1'b1;
        end else begin
          lo_load = 1'b1;
          pc_step = 1'b1;
          done    = (n_ops == 2'd1);
        end
        phase_nxt = done ? PH_OPC : PH_OP2;
      end
      PH_OP2: begin
        hi_load   = 1'b1;
        pc_step   = 1'b1;
        done      = 1'b1;
        phase_nxt = PH_OPC;
      end
      default: phase_nxt = PH_OPC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_OPC;
    else     phase <= phase_nxt;
  end

endmodule

// File: rtl/fetch_capture.sv
module fetch_capture #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   rdata,
  input  logic            ir_load,
  input  logic            lo_load,
  input  logic            hi_load,
  output logic [DW-1:0]   ir,
  output logic [2*DW-1:0] opnd
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ir   <= '0;
      opnd <= '0;
    end else begin
      if (ir_load) ir <= rdata;
      if (lo_load) opnd <= {{DW{1'b0}}, rdata};
      else if (hi_load) opnd[2*DW-1:DW] <= rdata;
    end
  end

endmodule

// File: rtl/insn_fetch_sequencer.sv
module insn_fetch_sequencer
  import fetch_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   reset_vector,
  input  logic [1:0]      len_class,
  input  logic [DW-1:0]   bus_rdata,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_rd,
  output logic [DW-1:0]   opcode_q,
  output logic [2*DW-1:0] operand_q,
  output logic [1:0]      cycle_idx,
  output logic            fetch_done
);

  phase_e        phase;
  logic          pc_step;
  logic          ir_load;
  logic          lo_load;
  logic          hi_load;
  logic          dummy_rd;
  logic [AW-1:0] pc;

  fetch_phase_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .len_class(len_class),
    .phase    (phase),
    .pc_step  (pc_step),
    .ir_load  (ir_load),
    .lo_load  (lo_load),
    .hi_load  (hi_load),
    .dummy_rd (dummy_rd),
    .done     (fetch_done)
  );

  fetch_pc_reg #(.AW(AW)) u_pc (
    .clk         (clk),
    .rst         (rst),
    .reset_vector(reset_vector),
    .step        (pc_step),
    .pc          (pc)
  );

  fetch_capture #(.DW(DW)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .rdata  (bus_rdata),
    .ir_load(ir_load),
    .lo_load(lo_load),
    .hi_load(hi_load),
    .ir     (opcode_q),
    .opnd   (operand_q)
  );

  // Address comes from the counter before this cycle's increment.
  assign bus_addr  = pc;
  assign bus_rd    = ~rst;
  assign cycle_idx = phase;

endmodule

// File: rtl/fetch_seq_checker.sv
module fetch_seq_checker #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic [DW-1:0] opcode_q,
  input logic [1:0]    cycle_idx,
  input logic          fetch_done,
  input logic          dummy_rd,
  input logic          pc_step
);

  // R2 and R8: the opcode cycle advances the address by one, with wrap.
  assert_opcode_step_R2: assert property (@(posedge clk) disable iff (rst)
    (cycle_idx == 2'd0) |=> (bus_addr == $past(bus_addr) + {{(AW-1){1'b0}}, 1'b1}));

  assert_read_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rd);

  // R3: a dummy read keeps the address and hands over to an opcode fetch.
  assert_dummy_hold_R3: assert property (@(posedge clk) disable iff (rst)
    dummy_rd |=> ((bus_addr == $past(bus_addr)) && (cycle_idx == 2'd0)));

  assert_dummy_no_step_R3: assert property (@(posedge clk) disable iff (rst)
    dummy_rd |-> !pc_step);

  // R5: the second operand cycle always ends the instruction.
  assert_third_done_R5: assert property (@(posedge clk) disable iff (rst)
    (cycle_idx == 2'd2) |-> fetch_done);

  assert_idx_legal_R6: assert property (@(posedge clk) disable iff (rst)
    cycle_idx != 2'd3);

  assert_done_return_R7: assert property (@(posedge clk) disable iff (rst)
    fetch_done |=> (cycle_idx == 2'd0));

  assert_ir_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (cycle_idx != 2'd0) |=> $stable(opcode_q));

endmodule

bind insn_fetch_sequencer fetch_seq_checker #(.AW(AW), .DW(DW)) u_fetch_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .opcode_q  (opcode_q),
  .cycle_idx (cycle_idx),
  .fetch_done(fetch_done),
  .dummy_rd  (dummy_rd),
  .pc_step   (pc_step)
);

// File: tb/test_insn_fetch_sequencer.sv
module test_insn_fetch_sequencer;

  typedef struct {
    logic [15:0] pc;
    logic [7:0]  opc;
    int          ops;
    logic [15:0] opnd;
    logic [15:0] nxt;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] reset_vector = 16'h0000;
  logic [1:0]  len_class;
  logic [7:0]  bus_rdata;
  logic [15:0] bus_addr;
  logic        bus_rd;
  logic [7:0]  opcode_q;
  logic [15:0] operand_q;
  logic [1:0]  cycle_idx;
  logic        fetch_done;

  logic [7:0]  mem [256];
  exp_t        sb_q[$];
  exp_t        cur;
  logic [15:0] wr_pc;
  logic [15:0] exp_opnd;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          active = 1'b1;
  bit          pending = 1'b0;
  int          cyc_cnt = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  // Bench-side decode: length class is the low two opcode bits.
  assign len_class = opcode_q[1:0];
  assign bus_rdata = mem[bus_addr[7:0]];

  insn_fetch_sequencer i_insn_fetch_sequencer (
    .clk         (clk),
    .rst         (rst),
    .reset_vector(reset_vector),
    .len_class   (len_class),
    .bus_rdata   (bus_rdata),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .opcode_q    (opcode_q),
    .operand_q   (operand_q),
    .cycle_idx   (cycle_idx),
    .fetch_done  (fetch_done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Driver: places an instruction in memory and queues its prediction.
  task automatic put_insn(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi);
    exp_t e;
    int   n;
    n = (op[1:0] == 2'b01) ? 1 : (op[1:0] == 2'b10) ? 2 : 0;
    mem[wr_pc[7:0]] = op;
    if (n >= 1) mem[8'(wr_pc + 16'd1)] = lo;
    if (n == 2) mem[8'(wr_pc + 16'd2)] = hi;
    if (n == 1) exp_opnd = {8'h00, lo};
    if (n == 2) exp_opnd = {hi, lo};
    e.pc   = wr_pc;
    e.opc  = op;
    e.ops  = n;
    e.opnd = exp_opnd;
    e.nxt  = wr_pc + 16'(1 + n);
    sb_q.push_back(e);
    wr_pc = e.nxt;
  endtask

  task automatic do_reset(input logic [15:0] vec);
    @(posedge clk); #1;
    rst = 1'b1;
    reset_vector = vec;
    wr_pc = vec;
    exp_opnd = 16'h0000;
    repeat (2) @(posedge clk);
    #1;
    check(bus_rd == 1'b0, "R1 bus_rd in reset", 32'(bus_rd), 32'd0);
  endtask

  task automatic release_reset(input logic [15:0] vec);
    rst = 1'b0;
    #1;
    check(bus_addr == vec, "R1 bus_addr after reset", 32'(bus_addr), 32'(vec));
    check(cycle_idx == 2'd0, "R1 cycle_idx after reset", 32'(cycle_idx), 32'd0);
    check(opcode_q == 8'h00, "R1 opcode_q after reset", 32'(opcode_q), 32'd0);
    check(operand_q == 16'h0000, "R1 operand_q after reset", 32'(operand_q), 32'd0);
    check(bus_rd == 1'b1, "R2 bus_rd after reset", 32'(bus_rd), 32'd1);
    @(negedge clk);
    wait (!active);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pops predictions and compares them at the ports.
  always @(negedge clk) begin
    if (rst) begin
      active  = 1'b1;
      pending = 1'b0;
      cyc_cnt = 0;
    end else if (active) begin
      cyc_cnt++;
      if (pending) begin
        pending = 1'b0;
        check(operand_q == cur.opnd, "R3/R4/R5 operand_q", 32'(operand_q), 32'(cur.opnd));
        check(bus_addr == cur.nxt, "R3/R8 next opcode address", 32'(bus_addr), 32'(cur.nxt));
      end
      case (cycle_idx)
        2'd0: begin
          if (sb_q.size() == 0) begin
            active = 1'b0;
          end else begin
            cur = sb_q.pop_front();
            cyc_cnt = 1;
            check(bus_addr == cur.pc, "R2 opcode address", 32'(bus_addr), 32'(cur.pc));
            check(bus_rd == 1'b1, "R2 read strobe", 32'(bus_rd), 32'd1);
            check(fetch_done == 1'b0, "R7 done low in opcode cycle", 32'(fetch_done), 32'd0);
          end
        end
        2'd1: begin
          check(bus_addr == cur.pc + 16'd1, "R3 second-cycle read address", 32'(bus_addr), 32'(cur.pc + 16'd1));
          check(bus_rd == 1'b1, "R3 second-cycle read strobe", 32'(bus_rd), 32'd1);
          check(opcode_q == cur.opc, "R2/R9 opcode_q", 32'(opcode_q), 32'(cur.opc));
          check(fetch_done == (cur.ops < 2), "R6/R7 done in cycle 1", 32'(fetch_done), 32'(cur.ops < 2));
        end
        2'd2: begin
          check(cur.ops == 2, "R5/R6 third cycle only for two operands", 32'(cur.ops), 32'd2);
          check(bus_addr == cur.pc + 16'd2, "R5 high byte address", 32'(bus_addr), 32'(cur.pc + 16'd2));
          check(opcode_q == cur.opc, "R9 opcode_q held", 32'(opcode_q), 32'(cur.opc));
          check(fetch_done == 1'b1, "R7 done in cycle 2", 32'(fetch_done), 32'd1);
        end
        default: check(1'b0, "R6 cycle_idx legal", 32'(cycle_idx), 32'd0);
      endcase
      if (active && fetch_done) begin
        check(cyc_cnt == ((cur.ops == 2) ? 3 : 2), "R7 instruction length in cycles",
              32'(cyc_cnt), 32'((cur.ops == 2) ? 3 : 2));
        pending = 1'b1;
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hEA;

    // Mixed stream covering every length class.
    do_reset(16'h1040);
    put_insn(8'h00, 8'h00, 8'h00);   // no operand, dummy read
    put_insn(8'hA9, 8'h37, 8'h00);   // one operand byte
    put_insn(8'h4E, 8'h34, 8'h12);   // two operand bytes
    put_insn(8'h7B, 8'h00, 8'h00);   // class 11, no operand
    put_insn(8'h01, 8'hFF, 8'h00);   // one byte clears high half
    put_insn(8'h02, 8'h00, 8'h80);
    put_insn(8'hEC, 8'h00, 8'h00);
    put_insn(8'h03, 8'h00, 8'h00);
    release_reset(16'h1040);

    // Wrap inside a two-byte operand fetch (R8).
    do_reset(16'hFFFE);
    put_insn(8'h06, 8'h9C, 8'h5D);
    put_insn(8'h03, 8'h00, 8'h00);
    put_insn(8'h01, 8'h77, 8'h00);
    release_reset(16'hFFFE);

    // Wrap in the opcode cycle of a no-operand instruction (R8, R3).
    do_reset(16'hFFFF);
    put_insn(8'h00, 8'h00, 8'h00);
    release_reset(16'hFFFF);

    // Wrap in the opcode cycle, then a one-byte operand at 0000 (R8, R4).
    do_reset(16'hFFFF);
    put_insn(8'h05, 8'h00, 8'h00);
    put_insn(8'h01, 8'h42, 8'h00);
    release_reset(16'hFFFF);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule